// File: doc/BRIEF.md
# Byte-Lane Static Memory with Dual Chip Selects

This block is a word-organized static memory. Its control port follows an asynchronous style: one chip select is active low, one is active high, and there is an active-low write strobe, an active-low output enable and an active-low enable for each byte lane. Every control input is sampled on the rising clock edge. A write commits on the edge where all write conditions hold. Read data and the per-lane drive enables are registered, so they appear one cycle after the sampled request.

The bidirectional 16-bit bus is split into an input bus and an output bus. The output bus comes with one drive-enable bit per byte lane, and an enclosing level uses these bits to build the tristate pads. A registered standby flag reports whether the chip was deselected on the last sampled edge. The default depth is 1024 words (10 address bits). Setting the address width to 19 gives the full 524,288-word array.

Top module: `bytelane_sram`

## Requirements
- R1: The block counts as selected only when `selN` is 0 and `selP` is 1. On an edge where it is not selected, nothing is written and `dOutEn` is 2'b00 in the following cycle.
- R2: While selected, a 0 on `wrN` at an edge writes the lanes of `dIn` whose lane enable is 0 into the word at `addr`. `oeN` has no effect on the write.
- R3: While selected, with `wrN`=1 and `oeN`=0 at an edge, the next cycle shows the stored data on each lane whose enable is 0, and that lane's `dOutEn` bit is 1.
- R4: While selected, with `wrN`=1 and `oeN`=1, `dOutEn` is 2'b00 in the next cycle (output disabled).
- R5: `laneN[0]` gates data bits 7:0 and `dOutEn[0]`. `laneN[1]` gates bits 15:8 and `dOutEn[1]`. With `laneN`=2'b11, no lane is read or written.
- R6: During a write, a lane whose enable is 1 keeps its stored value.
- R7: `dOutEn` is 2'b00 in the cycle that follows a sampled write.
- R8: `standby` is 1 in the cycle after an edge where the block was not selected, and 0 after an edge where it was.
- R9: An output lane whose `dOutEn` bit is 0 carries all zeros on `dOut`.
- R10: While `rstN` is low, `dOutEn` is 2'b00, `standby` is 1 and `dOut` is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rstN | input | 1 | Asynchronous active-low reset of the output registers |
| addr | input | ADDR_W | Word address |
| selN | input | 1 | Active-low chip select |
| selP | input | 1 | Active-high chip select |
| wrN | input | 1 | Active-low write strobe |
| oeN | input | 1 | Active-low output enable |
| laneN | input | 2 | Active-low byte lane enables (bit 0 lower, bit 1 upper) |
| dIn | input | 16 | Write data from the bus |
| dOut | output | 16 | Registered read data |
| dOutEn | output | 2 | Per-lane drive enable for the tristate bus |
| standby | output | 1 | Deselected on the last sampled edge |

## Verification
The hardest case to reach from the ports is a partial write that lands on a word whose other lane already holds known data. That case only shows up when the untouched lane is read back after the write. The stimulus first fills a range of words with full-width writes. It then mixes upper-only, lower-only and no-lane writes with reads that use different lane masks, and it tries writes with each chip select inactive on its own. A randomized phase then interleaves all modes over the pre-filled range, and a reference model predicts every registered output cycle by cycle.

// File: rtl/bls_pkg.sv
package bls_pkg;
  localparam int LANE_CNT = 2;

  // strobes from decode to datapath, one bit per byte lane
  typedef struct packed {
    logic [LANE_CNT-1:0] wrLane;
    logic [LANE_CNT-1:0] rdLane;
    logic                idle;
  } laneStrobe_t;
endpackage

// File: rtl/bls_ctrl.sv
module bls_ctrl
  import bls_pkg::*;
(
  input  logic                selN,
  input  logic                selP,
  input  logic                wrN,
  input  logic                oeN,
  input  logic [LANE_CNT-1:0] laneN,
  output laneStrobe_t         strb
);
  logic selected;
  logic writeMode;
  logic readMode;

  always_comb begin
    selected    = !selN && selP;
    writeMode   = selected && !wrN;
    readMode    = selected && wrN && !oeN;
    strb.idle   = !selected;
    strb.wrLane = writeMode ? ~laneN : '0;
    strb.rdLane = readMode  ? ~laneN : '0;
  end
endmodule

// File: rtl/bls_datapath.sv
module bls_datapath
  import bls_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int LANE_W = 8
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [ADDR_W-1:0]          addr,
  input  logic [LANE_CNT*LANE_W-1:0] dIn,
  input  laneStrobe_t                strb,
  output logic [LANE_CNT*LANE_W-1:0] dOut,
  output logic [LANE_CNT-1:0]        dOutEn,
  output logic                       standby
);
  localparam int DEPTH = 1 << ADDR_W;

  for (genvar g = 0; g < LANE_CNT; g++) begin : gLane
    logic [LANE_W-1:0] laneMem [DEPTH];
    logic [LANE_W-1:0] rdQ;
    logic              enQ;

    always_ff @(posedge clk) begin
      if (strb.wrLane[g]) laneMem[addr] <= dIn[g*LANE_W +: LANE_W];
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        rdQ <= '0;
        enQ <= 1'b0;
      end else begin
        enQ <= strb.rdLane[g];
        rdQ <= strb.rdLane[g] ? laneMem[addr] : '0;
      end
    end

    assign dOut[g*LANE_W +: LANE_W] = rdQ;
    assign dOutEn[g]                = enQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) standby <= 1'b1;
    else       standby <= strb.idle;
  end
endmodule

// File: rtl/bytelane_sram.sv
module bytelane_sram
  import bls_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              selN,
  input  logic              selP,
  input  logic              wrN,
  input  logic              oeN,
  input  logic [1:0]        laneN,
  input  logic [15:0]       dIn,
  output logic [15:0]       dOut,
  output logic [1:0]        dOutEn,
  output logic              standby
);
  localparam int LANE_W = 16 / LANE_CNT;

  laneStrobe_t strb;

  bls_ctrl u_ctrl (
    .selN  (selN),
    .selP  (selP),
    .wrN   (wrN),
    .oeN   (oeN),
    .laneN (laneN),
    .strb  (strb)
  );

  bls_datapath #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .addr    (addr),
    .dIn     (dIn),
    .strb    (strb),
    .dOut    (dOut),
    .dOutEn  (dOutEn),
    .standby (standby)
  );
endmodule

// File: rtl/bls_chk.sv
module bls_chk (
  input logic        clk,
  input logic        rstN,
  input logic        selN,
  input logic        selP,
  input logic        wrN,
  input logic        oeN,
  input logic [1:0]  laneN,
  input logic [15:0] dOut,
  input logic [1:0]  dOutEn,
  input logic        standby
);
  logic pastOk;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pastOk <= 1'b0;
    else       pastOk <= 1'b1;
  end

  // R1
  desel_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pastOk && $past(selN || !selP)) |-> (dOutEn == 2'b00));

  // R7
  no_drive_on_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pastOk && $past(!selN && selP && !wrN)) |-> (dOutEn == 2'b00));

  // R4
  oe_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pastOk && $past(!selN && selP && wrN && oeN)) |-> (dOutEn == 2'b00));

  // R3
  read_lanes_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pastOk && $past(!selN && selP && wrN && !oeN)) |-> (dOutEn == ~$past(laneN)));

  // R8
  standby_track_chk: assert property (@(posedge clk) disable iff (!rstN)
    pastOk |-> (standby == $past(selN || !selP)));

  // R9
  idle_lane_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((!dOutEn[0] -> dOut[7:0] == 8'h00) && (!dOutEn[1] -> dOut[15:8] == 8'h00)));
endmodule

bind bytelane_sram bls_chk u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .selN    (selN),
  .selP    (selP),
  .wrN     (wrN),
  .oeN     (oeN),
  .laneN   (laneN),
  .dOut    (dOut),
  .dOutEn  (dOutEn),
  .standby (standby)
);

// File: tb/bytelane_sram_tb.sv
module bytelane_sram_tb;
  localparam int ADDR_W = 10;
  localparam int DEPTH  = 1 << ADDR_W;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic              selN = 1'b1, selP = 1'b0, wrN = 1'b1, oeN = 1'b1;
  logic [1:0]        laneN = 2'b11;
  logic [15:0]       dIn = '0;
  logic [15:0]       dOut;
  logic [1:0]        dOutEn;
  logic              standby;

  int compared = 0;
  int mismatched = 0;

  typedef struct {
    logic [15:0] d;
    logic [1:0]  en;
    logic        sb;
    string       tag;
  } exp_t;
  exp_t q[$];

  logic [15:0] model [DEPTH];

  always #4 clk = ~clk;

  bytelane_sram #(.ADDR_W(ADDR_W)) u_dut (
    .clk(clk), .rstN(rstN), .addr(addr), .selN(selN), .selP(selP),
    .wrN(wrN), .oeN(oeN), .laneN(laneN), .dIn(dIn),
    .dOut(dOut), .dOutEn(dOutEn), .standby(standby)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] expv);
    compared++;
    if (act !== expv) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", tag, act, expv);
    end
  endtask

  // driver: apply one cycle of controls and push the predicted result
  task automatic step(input logic sN, input logic sP, input logic wN, input logic oN,
                      input logic [1:0] lN, input int a, input logic [15:0] d, input string tag);
    exp_t e;
    logic sel;
    logic [15:0] mask;
    @(negedge clk);
    selN = sN; selP = sP; wrN = wN; oeN = oN; laneN = lN;
    addr = a[ADDR_W-1:0]; dIn = d;
    sel  = !sN && sP;
    mask = {{8{!lN[1]}}, {8{!lN[0]}}};
    e.tag = tag; e.sb = !sel; e.en = 2'b00; e.d = 16'h0000;
    if (sel && !wN) begin
      model[a] = (model[a] & ~mask) | (d & mask);
    end else if (sel && !oN) begin
      e.en = ~lN;
      e.d  = model[a] & mask;
    end
    q.push_back(e);
  endtask

  // monitor
  always @(posedge clk) begin
    #2;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      check({e.tag, " data"},    {16'h0, dOut},   {16'h0, e.d});
      check({e.tag, " enable"},  {30'h0, dOutEn}, {30'h0, e.en});
      check({e.tag, " standby"}, {31'h0, standby}, {31'h0, e.sb});
    end
  end

  initial begin
    #(8 * 200000);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    check("R10 dOutEn", {30'h0, dOutEn}, 32'h0);
    check("R10 standby", {31'h0, standby}, 32'h1);
    check("R10 dOut", {16'h0, dOut}, 32'h0);
    @(negedge clk);
    rstN = 1'b1;

    // R2 full-word writes, oeN both values (also R7)
    for (int i = 0; i < 16; i++)
      step(1'b0, 1'b1, 1'b0, i[0], 2'b00, i, 16'hA000 + 16'(i * 16'h0111), "R2/R7");
    step(1'b0, 1'b1, 1'b0, 1'b0, 2'b00, DEPTH - 1, 16'h5AA5, "R2");
    // R3 reads back both lanes
    for (int i = 0; i < 16; i++)
      step(1'b0, 1'b1, 1'b1, 1'b0, 2'b00, i, 16'hFFFF, "R3");
    step(1'b0, 1'b1, 1'b1, 1'b0, 2'b00, DEPTH - 1, 16'h0, "R3");
    // R6 upper-only write keeps lower; R5 lane mapping
    step(1'b0, 1'b1, 1'b0, 1'b1, 2'b01, 3, 16'h3C7E, "R6");
    step(1'b0, 1'b1, 1'b1, 1'b0, 2'b00, 3, 16'h0, "R6");
    step(1'b0, 1'b1, 1'b0, 1'b0, 2'b10, 4, 16'h1299, "R6");
    step(1'b0, 1'b1, 1'b1, 1'b0, 2'b00, 4, 16'h0, "R6");
    // R5 / R9 single lane reads and no-lane accesses
    step(1'b0, 1'b1, 1'b1, 1'b0, 2'b10, 5, 16'h0, "R5/R9");
    step(1'b0, 1'b1, 1'b1, 1'b0, 2'b01, 5, 16'h0, "R5/R9");
    step(1'b0, 1'b1, 1'b0, 1'b1, 2'b11, 6, 16'hDEAD, "R5");
    step(1'b0, 1'b1, 1'b1, 1'b0, 2'b11, 6, 16'h0, "R5");
    step(1'b0, 1'b1, 1'b1, 1'b0, 2'b00, 6, 16'h0, "R5");
    // R1 write attempts with either select inactive, R8 standby
    step(1'b1, 1'b1, 1'b0, 1'b0, 2'b00, 7, 16'hBEEF, "R1/R8");
    step(1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 7, 16'hCAFE, "R1/R8");
    step(1'b1, 1'b0, 1'b1, 1'b0, 2'b00, 7, 16'h0, "R1/R8");
    step(1'b0, 1'b1, 1'b1, 1'b0, 2'b00, 7, 16'h0, "R1");
    // R4 output disabled
    step(1'b0, 1'b1, 1'b1, 1'b1, 2'b00, 8, 16'h0, "R4");
    step(1'b0, 1'b1, 1'b1, 1'b1, 2'b01, 9, 16'h0, "R4");
    // mixed random phase over the pre-filled range
    for (int i = 0; i < 400; i++) begin
      int r;
      r = int'($urandom_range(0, 9));
      step(r == 0, r != 1, $urandom_range(0, 2) != 0, $urandom_range(0, 3) == 0,
           2'($urandom_range(0, 3)), int'($urandom_range(0, 15)),
           16'($urandom), "R2/R3/R6 mix");
    end
    repeat (3) @(negedge clk);
    check("R3 queue drained", q.size(), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule